// File: doc/BRIEF.md
# UART Line Status and Interrupt Identification

This block produces the line status byte, the interrupt identification code and the interrupt request line for a 16550-style UART with transmit and receive FIFOs. It does not store characters. The FIFO storage reports its occupancy to the block, and the receiver reports error flags as pulses. The host read strobes for the status and identification registers come in as single-cycle inputs. The configured character format also comes in, and the block uses it to time the transmitter-empty indication.

The block supports two ways of working. In interrupt mode, a receive trigger level, a character timeout and a transmitter-empty condition each raise a prioritised interrupt. In polled mode, software clears the interrupt enables while the FIFOs stay on. Each direction can be polled on its own, and in this mode only the status byte reflects the FIFO state.

When the transmit FIFO drains, the transmitter-empty flag normally rises on the next clock. If the FIFO never held two bytes at once since the flag last rose, the rise is instead held back for one character time less the final stop bit. That time is counted in baud ticks.

Top module: `uart_lsr_intc`

## Requirements
- R1: Status bit 0 is high exactly while `rx_count` is nonzero.
- R2: An `err_set` pulse sets a sticky status bit on the next clock. `err_set[0]` sets bit 1 (overrun), `err_set[1]` sets bit 2 (parity), `err_set[2]` sets bit 3 (framing) and `err_set[3]` sets bit 4 (break). A `lsr_rd` strobe clears bits 1 to 4 on the next clock. A set in the same cycle as a read wins.
- R3: Status bit 7 rises on the clock after `rx_err_held` is high. It clears only on a `lsr_rd` strobe taken while `rx_err_held` is low.
- R4: Status bit 5 drops on the clock after `tx_count` becomes nonzero. Status bit 6 is high only when bit 5 and `tsr_empty` are both high.
- R5: If `tx_count` reached 2 or more since bit 5 last rose, bit 5 rises on the first clock after `tx_count` returns to zero.
- R6: Otherwise bit 5 rises after D baud ticks that follow the first clock of the empty FIFO. D = 1 + (5 + `data_len`) + `parity_en` + `stop2`, which is the start, data and parity bits plus any stop bit but the last. Clocks without `baud_tick` do not advance the count. With a tick on every clock, bit 5 rises D+1 clocks after the FIFO empties.
- R7: Identification codes run from highest priority to lowest: 0110 line error (`ier[2]`), 0100 receive data, 1100 character timeout (`ier[0]` for both), 0010 transmitter empty (`ier[1]`), 0000 modem status (`ier[3]`) and 0001 for none. Receive data outranks timeout within their shared level.
- R8: With `ier[0]` low, neither 0100 nor 1100 is reported, and the status byte still tracks the FIFOs. With the FIFOs on, receive data means `rx_trig` and timeout means `rx_timeout`. With the FIFOs off, receive data means a nonzero `rx_count` and no timeout is reported.
- R9: A change of `fifo_en` while the transmit FIFO is empty makes the transmitter-empty interrupt pending on the next clock, with no delay.
- R10: The transmitter-empty interrupt becomes pending when bit 5 rises or when `ier[1]` rises while bit 5 is high. It is withdrawn by `iir_rd` while code 0010 is shown, or by a nonzero `tx_count`.
- R11: After reset the status byte is 0x60 (with `tsr_empty` high) and the code is 0001. `irq` is high exactly when the code is not 0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_err_held | input | 1 | An errored character is in the receive FIFO |
| err_set | input | 4 | Error pulses {break, framing, parity, overrun} |
| rx_trig | input | 1 | Receive trigger level reached |
| rx_timeout | input | 1 | Character timeout condition |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| tsr_empty | input | 1 | Transmit shift register empty |
| baud_tick | input | 1 | One bit time elapsed |
| data_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present |
| stop2 | input | 1 | Two stop bits |
| ier | input | 4 | Interrupt enables |
| fifo_en | input | 1 | FIFOs enabled |
| msr_int | input | 1 | Modem status change pending |
| lsr_rd | input | 1 | Status register read strobe |
| iir_rd | input | 1 | Identification register read strobe |
| lsr | output | 8 | Line status byte |
| iid | output | 4 | Interrupt identification code |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the delayed transmitter-empty rise. It needs a transmit FIFO that never held two bytes since the last rise, followed by a drain, with the result checked on exactly the clock where the character-time count expires. The stimulus writes one byte, drains it, and samples one clock before and one clock on the expected edge. It then repeats the drain in a different character format with `baud_tick` held low, to show that the count pauses. A burst that takes the FIFO to two bytes precedes a drain, to show the immediate path. A `fifo_en` toggle after the pending interrupt has been read away shows the forced re-raise.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int ERR_W = 4;

  typedef enum logic [3:0] {
    IID_MSR  = 4'b0000,
    IID_NONE = 4'b0001,
    IID_THR  = 4'b0010,
    IID_RXD  = 4'b0100,
    IID_LSR  = 4'b0110,
    IID_TMO  = 4'b1100
  } iid_e;
endpackage

// File: rtl/uart_lsr_flags.sv
module uart_lsr_flags
  import uart_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] err_set,
  input  logic             rx_err_held,
  input  logic             lsr_rd,
  output logic [ERR_W-1:0] err_q,
  output logic             err7_q
);
  logic [ERR_W-1:0] err_d;
  logic             err7_d;

  always_comb begin
    err_d  = lsr_rd ? '0 : err_q;
    err_d  = err_d | err_set;
    err7_d = err7_q;
    if (lsr_rd && !rx_err_held) err7_d = 1'b0;
    if (rx_err_held)            err7_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      err7_q <= 1'b0;
    end else begin
      err_q  <= err_d;
      err7_q <= err7_d;
    end
  end

  AST_ERR_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && err_set == '0) |=> (err_q == '0)); // R2
  AST_ERR7_FOLLOWS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_held |=> err7_q); // R3
endmodule

// File: rtl/uart_thre_delay.sv
module uart_thre_delay #(
  parameter int CNT_W = 5,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             fifo_chg,
  input  logic             baud_tick,
  input  logic [1:0]       data_len,
  input  logic             parity_en,
  input  logic             stop2,
  output logic             thre_q,
  output logic             thre_evt
);
  logic             thre_d, seen_two_q, seen_two_d, busy_q, busy_d;
  logic [DLY_W-1:0] cnt_q, cnt_d, dly;
  logic             tx_empty;

  assign tx_empty = (tx_count == '0);
  assign dly = DLY_W'(6) + DLY_W'(data_len) + DLY_W'(parity_en) + DLY_W'(stop2);

  always_comb begin
    thre_d = thre_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (!tx_empty) begin
      thre_d = 1'b0;
      busy_d = 1'b0;
    end else if (fifo_chg) begin
      thre_d = 1'b1;
      busy_d = 1'b0;
    end else if (!thre_q && !busy_q) begin
      if (seen_two_q) begin
        thre_d = 1'b1;
      end else begin
        busy_d = 1'b1;
        cnt_d  = dly;
      end
    end else if (busy_q && baud_tick) begin
      if (cnt_q <= DLY_W'(1)) begin
        thre_d = 1'b1;
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - DLY_W'(1);
      end
    end
    seen_two_d = (thre_d && !thre_q) ? 1'b0
                 : (seen_two_q || (tx_count >= CNT_W'(2)));
    thre_evt   = (thre_d && !thre_q) || (fifo_chg && tx_empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre_q     <= 1'b1;
      seen_two_q <= 1'b0;
      busy_q     <= 1'b0;
      cnt_q      <= '0;
    end else begin
      thre_q     <= thre_d;
      seen_two_q <= seen_two_d;
      busy_q     <= busy_d;
      cnt_q      <= cnt_d;
    end
  end

  AST_THRE_DROPS_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count != '0) |=> !thre_q); // R4
  AST_THRE_SHORT_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(thre_q) && !$past(seen_two_q) && !$past(fifo_chg)) |-> $past(busy_q)); // R6
endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio
  import uart_stat_pkg::*;
(
  input  logic       lsr_req,
  input  logic       rxd_req,
  input  logic       tmo_req,
  input  logic       thr_req,
  input  logic       msr_req,
  output logic [3:0] iid
);
  iid_e code;

  always_comb begin
    if (lsr_req)      code = IID_LSR;
    else if (rxd_req) code = IID_RXD;
    else if (tmo_req) code = IID_TMO;
    else if (thr_req) code = IID_THR;
    else if (msr_req) code = IID_MSR;
    else              code = IID_NONE;
    iid = code;
  end
endmodule

// File: rtl/uart_lsr_intc.sv
module uart_lsr_intc
  import uart_stat_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DLY_W      = 4,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_err_held,
  input  logic [ERR_W-1:0] err_set,
  input  logic             rx_trig,
  input  logic             rx_timeout,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             tsr_empty,
  input  logic             baud_tick,
  input  logic [1:0]       data_len,
  input  logic             parity_en,
  input  logic             stop2,
  input  logic [3:0]       ier,
  input  logic             fifo_en,
  input  logic             msr_int,
  input  logic             lsr_rd,
  input  logic             iir_rd,
  output logic [7:0]       lsr,
  output logic [3:0]       iid,
  output logic             irq
);
  logic [ERR_W-1:0] err_q;
  logic             err7_q, thre_q, thre_evt;
  logic             fifo_en_q, fifo_chg, ier1_q;
  logic             pend_q, pend_d;
  logic             rxd_req, tmo_req;

  assign fifo_chg = (fifo_en != fifo_en_q);

  uart_lsr_flags u_flags (
    .clk(clk), .rst_n(rst_n), .err_set(err_set), .rx_err_held(rx_err_held),
    .lsr_rd(lsr_rd), .err_q(err_q), .err7_q(err7_q)
  );

  uart_thre_delay #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_thre (
    .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .fifo_chg(fifo_chg),
    .baud_tick(baud_tick), .data_len(data_len), .parity_en(parity_en),
    .stop2(stop2), .thre_q(thre_q), .thre_evt(thre_evt)
  );

  always_comb begin
    rxd_req = ier[0] && (fifo_en ? rx_trig : (rx_count != '0));
    tmo_req = ier[0] && fifo_en && rx_timeout;
    pend_d  = pend_q;
    if ((iir_rd && iid == IID_THR) || (tx_count != '0)) pend_d = 1'b0;
    if (thre_evt || (ier[1] && !ier1_q && thre_q))      pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en_q <= 1'b0;
      ier1_q    <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      fifo_en_q <= fifo_en;
      ier1_q    <= ier[1];
      pend_q    <= pend_d;
    end
  end

  uart_iid_prio u_prio (
    .lsr_req(ier[2] && (err_q != '0)), .rxd_req(rxd_req), .tmo_req(tmo_req),
    .thr_req(ier[1] && pend_q), .msr_req(ier[3] && msr_int), .iid(iid)
  );

  assign lsr = {err7_q, thre_q && tsr_empty, thre_q, err_q, rx_count != '0};
  assign irq = (iid != IID_NONE);

  AST_POLLED_NO_RX_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !ier[0] |-> (iid != IID_RXD && iid != IID_TMO)); // R8
  AST_FIFO_TOGGLE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_chg && tx_count == '0) |=> pend_q); // R9
  AST_CODE_IS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    iid inside {IID_MSR, IID_NONE, IID_THR, IID_RXD, IID_LSR, IID_TMO}); // R7
endmodule

// File: tb/uart_lsr_intc_test.sv
`timescale 1ns/1ps
module uart_lsr_intc_test;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] rx_count, tx_count;
  logic          rx_err_held, rx_trig, rx_timeout, tsr_empty, baud_tick;
  logic [3:0]    err_set, ier;
  logic [1:0]    data_len;
  logic          parity_en, stop2, fifo_en, msr_int, lsr_rd, iir_rd;
  logic [7:0]    lsr;
  logic [3:0]    iid;
  logic          irq;

  typedef struct {
    logic [7:0] lsr;
    logic [3:0] iid;
    string      tag;
  } exp_t;

  exp_t queue_q[$];
  event sample_ev;
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  uart_lsr_intc uut (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .rx_err_held(rx_err_held),
    .err_set(err_set), .rx_trig(rx_trig), .rx_timeout(rx_timeout),
    .tx_count(tx_count), .tsr_empty(tsr_empty), .baud_tick(baud_tick),
    .data_len(data_len), .parity_en(parity_en), .stop2(stop2), .ier(ier),
    .fifo_en(fifo_en), .msr_int(msr_int), .lsr_rd(lsr_rd), .iir_rd(iir_rd),
    .lsr(lsr), .iid(iid), .irq(irq)
  );

  // monitor: pops expected items and compares with outputs
  always @(sample_ev) begin
    while (queue_q.size() > 0) begin
      exp_t e;
      e = queue_q.pop_front();
      n_chk++;
      if (lsr !== e.lsr || iid !== e.iid || irq !== (e.iid != 4'b0001)) begin
        n_bad++;
        $display("FAIL %s: lsr=%h iid=%b irq=%b expected lsr=%h iid=%b irq=%b",
                 e.tag, lsr, iid, irq, e.lsr, e.iid, e.iid != 4'b0001);
      end
    end
  end

  task automatic expect_out(input logic [7:0] l, input logic [3:0] c, input string tag);
    exp_t e;
    e.lsr = l; e.iid = c; e.tag = tag;
    queue_q.push_back(e);
    -> sample_ev;
    #0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rx_count = 0; tx_count = 0; rx_err_held = 0; rx_trig = 0;
    rx_timeout = 0; tsr_empty = 1; baud_tick = 1; err_set = 0; ier = 0;
    data_len = 2'd3; parity_en = 0; stop2 = 0; fifo_en = 0; msr_int = 0;
    lsr_rd = 0; iir_rd = 0;
    step(3); rst_n = 1; step(1);
    expect_out(8'h60, 4'b0001, "R11 reset state");

    rx_count = 3; step(1);
    expect_out(8'h61, 4'b0001, "R1 rx data flag");

    err_set = 4'b0101; step(1); err_set = 0;
    expect_out(8'h6B, 4'b0001, "R2 overrun+framing sticky");
    step(2);
    expect_out(8'h6B, 4'b0001, "R2 bits held");

    ier = 4'b0100; step(1);
    expect_out(8'h6B, 4'b0110, "R7 line error code");
    ier = 4'b0101; step(1);
    expect_out(8'h6B, 4'b0110, "R7 line error over rx data");

    lsr_rd = 1; step(1); lsr_rd = 0;
    expect_out(8'h61, 4'b0100, "R2 read clears, R8 rx data fifo off");

    rx_err_held = 1; step(1);
    expect_out(8'hE1, 4'b0100, "R3 bit7 set");
    lsr_rd = 1; step(1); lsr_rd = 0;
    expect_out(8'hE1, 4'b0100, "R3 read while held keeps bit7");
    rx_err_held = 0; step(1);
    expect_out(8'hE1, 4'b0100, "R3 sticky after held drops");
    lsr_rd = 1; step(1); lsr_rd = 0;
    expect_out(8'h61, 4'b0100, "R3 read clears bit7");

    fifo_en = 1; step(1);
    expect_out(8'h61, 4'b0001, "R8 fifo on, no trigger");
    rx_timeout = 1; step(1);
    expect_out(8'h61, 4'b1100, "R8 timeout code");
    rx_trig = 1; step(1);
    expect_out(8'h61, 4'b0100, "R7 rx data over timeout");
    ier = 4'b0000; step(1);
    expect_out(8'h61, 4'b0001, "R8 polled rx");

    rx_count = 0; rx_trig = 0; rx_timeout = 0;
    ier = 4'b0010; step(1);
    expect_out(8'h60, 4'b0010, "R10 thre pending");
    iir_rd = 1; step(1); iir_rd = 0;
    expect_out(8'h60, 4'b0001, "R10 iir read clears");

    // single byte then drain: delayed path, D = 9
    tx_count = 1; step(1);
    expect_out(8'h00, 4'b0001, "R4 thre drops");
    tx_count = 0; step(9);
    expect_out(8'h00, 4'b0001, "R6 still delayed");
    step(1);
    expect_out(8'h60, 4'b0010, "R6 delayed rise, R10 pending");

    // two bytes at once: immediate path
    tx_count = 2; step(1); tx_count = 1; step(1);
    expect_out(8'h00, 4'b0001, "R10 pending withdrawn");
    tx_count = 0; step(1);
    expect_out(8'h60, 4'b0010, "R5 immediate rise");

    // D = 8 with paused ticks
    data_len = 2'd0; parity_en = 1; stop2 = 1;
    tx_count = 1; step(1);
    tx_count = 0; baud_tick = 0; step(12);
    expect_out(8'h00, 4'b0001, "R6 no ticks no rise");
    baud_tick = 1; step(7);
    expect_out(8'h00, 4'b0001, "R6 one tick short");
    step(1);
    expect_out(8'h60, 4'b0010, "R6 rise after 8 ticks");
    tsr_empty = 0; step(1);
    expect_out(8'h20, 4'b0010, "R4 shift register busy");
    tsr_empty = 1;

    iir_rd = 1; step(1); iir_rd = 0;
    expect_out(8'h60, 4'b0001, "R10 cleared before toggle");
    fifo_en = 0; step(1);
    expect_out(8'h60, 4'b0010, "R9 fifo toggle immediate");

    ier = 4'b1010; msr_int = 1; step(1);
    expect_out(8'h60, 4'b0010, "R7 thre over modem");
    iir_rd = 1; step(1); iir_rd = 0;
    expect_out(8'h60, 4'b0000, "R7 modem code");
    msr_int = 0; step(1);
    expect_out(8'h60, 4'b0001, "R11 irq low when none");

    step(1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule